// File: doc/BRIEF.md
# Multi-Line Receive Silo

This block gathers characters from up to sixteen serial receivers into one shared FIFO. Each receiver presents a one-cycle strobe with a character byte and three error flags. The block stamps every character with the number of the line it came from and its error flags, then queues the result. Software drains the queue by reading one register again and again, and each read removes one entry. Bit 15 of the returned word shows whether the word holds a real character, so software stops reading when that bit is clear.

Each line has its own holding stage. A priority selector moves one held character per cycle into the FIFO. Characters that arrive on several lines in the same cycle are therefore queued in ascending line order. Software can hold back the receive interrupt until the queue is filled past a programmable alarm level. Bursty input then costs one interrupt per batch and not one per character.

Top module: `rxs_silo`

## Requirements
- R1: After reset the interrupt output is low, the read data port is 0, and the silo is empty, so reading address 1 returns 0x0000.
- R2: A read of the next-character register (address 1) that finds an entry returns a word laid out as follows: bit 15 = 1, bit 14 = overrun, bit 13 = framing error (break), bit 12 = parity error, bits 11:8 = line number, bits 7:0 = character. The value appears on `reg_rdata` in the cycle after the read strobe.
- R3: Characters are returned in the order they arrived, and each successful read of address 1 removes exactly one entry.
- R4: When several lines strobe in the same cycle, their characters are stored in ascending order of line number.
- R5: Reading address 1 while the silo is empty returns 0x0000 and leaves the silo contents and fill level unchanged.
- R6: The silo holds DEPTH (default 64) entries. A character that reaches the silo while it is full is dropped, and the next character that is stored has its overrun bit (bit 14) set.
- R7: With the receive interrupt enable set (control register, address 0, bit 6), `irq` goes high when the fill level exceeds the alarm level (address 2). An alarm level of 0 raises `irq` for any stored character. `irq` follows the fill level with one cycle of register delay.
- R8: With control bit 6 clear, `irq` stays low whatever the fill level.
- R9: Reading address 0 returns the enable in bit 6 and 0 in all other bits. Reading address 2 returns the alarm level that was last written.
- R10: If a line strobes again while its previous character is still waiting in its holding stage, the new character is dropped and the waiting character is stored with its overrun bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | NUM_LINES | Per-line one-cycle character strobe |
| line_data | input | 8*NUM_LINES | Per-line character byte, line i at bits 8i+7:8i |
| line_perr | input | NUM_LINES | Per-line parity error flag |
| line_ferr | input | NUM_LINES | Per-line framing error (break) flag |
| line_oerr | input | NUM_LINES | Per-line receiver overrun flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 next character, 2 alarm level |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after a read |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions check on every cycle that the FIFO fill level stays within its depth and moves by exactly one on each accepted store or removal. They also check that at most one line is granted per cycle, that `irq` tracks the enable bit and the comparison with the alarm level, and that a read of the next-character register returns 0 when the silo is empty and a word with bit 15 set when it is not. Some behaviour can only be shown by the bench scenarios with known stimulus: the exact field placement in the read word, the ascending order of same-cycle arrivals, first-in-first-out order, the dropping of characters at full capacity with the overrun mark on the next stored entry, and the overrun mark when a line strobes twice before its character is taken.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int WORD_W  = 16;
  localparam int CHAR_W  = 8;
  localparam int LINE_W  = 4;
  localparam int IE_BIT  = 6;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_NEXT  = 2'd1;
  localparam logic [1:0] ADDR_ALARM = 2'd2;

  // Stored entry: read word bits 14:0 in order
  typedef struct packed {
    logic              oerr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rxs_entry_t;

  localparam int ENTRY_W = $bits(rxs_entry_t);
endpackage

// File: rtl/rxs_capture.sv
module rxs_capture
  import rxs_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LINES-1:0]          stb,
  input  logic [NUM_LINES*CHAR_W-1:0]   data,
  input  logic [NUM_LINES-1:0]          perr,
  input  logic [NUM_LINES-1:0]          ferr,
  input  logic [NUM_LINES-1:0]          oerr,
  input  logic [NUM_LINES-1:0]          grant,
  output logic [NUM_LINES-1:0]          pending,
  output rxs_entry_t [NUM_LINES-1:0]    held
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [LINE_W-1:0] LINE_ID = LINE_W'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        pending[i] <= 1'b0;
        held[i]    <= '0;
      end else if (stb[i] && (!pending[i] || grant[i])) begin
        pending[i]   <= 1'b1;
        held[i].ch   <= data[i*CHAR_W +: CHAR_W];
        held[i].line <= LINE_ID;
        held[i].perr <= perr[i];
        held[i].ferr <= ferr[i];
        held[i].oerr <= oerr[i];
      end else if (stb[i]) begin
        // still waiting: drop new character, mark the waiting one
        held[i].oerr <= 1'b1;
      end else if (grant[i]) begin
        pending[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxs_arbiter.sv
module rxs_arbiter
  import rxs_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic [NUM_LINES-1:0]       pending,
  input  rxs_entry_t [NUM_LINES-1:0] held,
  output logic [NUM_LINES-1:0]       grant,
  output rxs_entry_t                 sel,
  output logic                       any
);
  always_comb begin
    grant = '0;
    sel   = '0;
    any   = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pending[i] && !any) begin
        grant[i] = 1'b1;
        sel      = held[i];
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int WIDTH = 15,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             push_ok,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  rxs_entry_t        head,
  input  logic              empty,
  input  logic [CW-1:0]     count,
  output logic              pop,
  output logic              ie,
  output logic [CW-1:0]     alarm,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic              sel_next_q;
  logic              valid_q;
  logic [WORD_W-1:0] misc_q;

  assign pop = reg_rd && (reg_addr == ADDR_NEXT) && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie    <= 1'b0;
      alarm <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL)  ie    <= reg_wdata[IE_BIT];
      if (reg_addr == ADDR_ALARM) alarm <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_next_q <= 1'b0;
      valid_q    <= 1'b0;
      misc_q     <= '0;
    end else if (reg_rd) begin
      sel_next_q <= (reg_addr == ADDR_NEXT);
      valid_q    <= !empty;
      case (reg_addr)
        ADDR_CTRL:  misc_q <= WORD_W'({ie, IE_BIT'(0)});
        ADDR_ALARM: misc_q <= WORD_W'(alarm);
        default:    misc_q <= '0;
      endcase
    end
  end

  always_comb begin
    if (!sel_next_q)  reg_rdata = misc_q;
    else if (valid_q) reg_rdata = {1'b1, head};
    else              reg_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ie && (count > alarm);
  end
endmodule

// File: rtl/rxs_silo.sv
module rxs_silo
  import rxs_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 64,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LINES-1:0]          line_stb,
  input  logic [NUM_LINES*CHAR_W-1:0]   line_data,
  input  logic [NUM_LINES-1:0]          line_perr,
  input  logic [NUM_LINES-1:0]          line_ferr,
  input  logic [NUM_LINES-1:0]          line_oerr,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [1:0]                    reg_addr,
  input  logic [WORD_W-1:0]             reg_wdata,
  output logic [WORD_W-1:0]             reg_rdata,
  output logic                          irq
);
  logic [NUM_LINES-1:0]       pending, grant;
  rxs_entry_t [NUM_LINES-1:0] held;
  rxs_entry_t                 sel, store, head;
  logic                       any, push_ok, full, empty, pop, ie;
  logic [CW-1:0]              count, alarm;
  logic                       lost_q;

  rxs_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk(clk), .rst(rst), .stb(line_stb), .data(line_data),
    .perr(line_perr), .ferr(line_ferr), .oerr(line_oerr),
    .grant(grant), .pending(pending), .held(held)
  );

  rxs_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
    .pending(pending), .held(held), .grant(grant), .sel(sel), .any(any)
  );

  always_comb begin
    store      = sel;
    store.oerr = sel.oerr | lost_q;
  end

  // a character was dropped at full capacity: mark the next stored one
  always_ff @(posedge clk) begin
    if (rst)              lost_q <= 1'b0;
    else if (any && full) lost_q <= 1'b1;
    else if (push_ok)     lost_q <= 1'b0;
  end

  rxs_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(any), .din(store), .pop(pop),
    .dout(head), .push_ok(push_ok), .count(count), .full(full), .empty(empty)
  );

  rxs_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head(head),
    .empty(empty), .count(count), .pop(pop), .ie(ie), .alarm(alarm),
    .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/rxs_silo_chk.sv
module rxs_silo_chk #(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 64,
  parameter int CW        = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] grant,
  input logic                 push_ok,
  input logic                 pop,
  input logic [CW-1:0]        count,
  input logic [CW-1:0]        alarm,
  input logic                 ie,
  input logic                 irq,
  input logic                 reg_rd,
  input logic [1:0]           reg_addr,
  input logic [15:0]          reg_rdata
);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
    (push_ok && !pop) |=> count == $past(count) + 1'b1);

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (pop && !push_ok) |=> count == $past(count) - 1'b1);

  a_r4_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r7_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (ie && count > alarm) |=> irq);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);

  a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd1 && count == '0) |=> reg_rdata == 16'h0000);

  a_r2_valid_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd1 && count != '0) |=> reg_rdata[15]);
endmodule

bind rxs_silo rxs_silo_chk #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .push_ok(push_ok), .pop(pop),
  .count(count), .alarm(alarm), .ie(ie), .irq(irq), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/rxs_silo_test.sv
`timescale 1ns/1ps
module rxs_silo_test;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] line_stb  = '0;
  logic [NL*8-1:0] line_data = '0;
  logic [NL-1:0] line_perr = '0, line_ferr = '0, line_oerr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rxs_silo #(.NUM_LINES(NL), .DEPTH(64)) uut (
    .clk(clk), .rst(rst), .line_stb(line_stb), .line_data(line_data),
    .line_perr(line_perr), .line_ferr(line_ferr), .line_oerr(line_oerr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send(input int ln, input logic [7:0] ch, input logic p, input logic f, input logic o);
    @(negedge clk);
    line_stb[ln] = 1'b1; line_data[ln*8 +: 8] = ch;
    line_perr[ln] = p; line_ferr[ln] = f; line_oerr[ln] = o;
    @(negedge clk);
    line_stb = '0; line_perr = '0; line_ferr = '0; line_oerr = '0;
  endtask

  task automatic expect_next(input string req, input logic [15:0] exp);
    logic [15:0] v;
    reg_read(2'd1, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", reg_rdata, 16'h0000);
    check("R1 irq after reset", {15'b0, irq}, 16'h0000);
    expect_next("R1 empty after reset", 16'h0000);
  endtask

  task automatic t_format();
    send(5, 8'hA5, 1'b1, 1'b0, 1'b0);
    send(9, 8'h00, 1'b0, 1'b1, 1'b0);
    send(15, 8'h3C, 1'b0, 1'b0, 1'b1);
    wait_cyc(3);
    expect_next("R2 parity line5", 16'h95A5);
    expect_next("R2 framing line9", 16'hA900);
    expect_next("R2 overrun line15", 16'hCF3C);
  endtask

  task automatic t_order();
    send(2, 8'h11, 0, 0, 0);
    send(7, 8'h22, 0, 0, 0);
    send(1, 8'h33, 0, 0, 0);
    wait_cyc(3);
    expect_next("R3 first", 16'h8211);
    expect_next("R3 second", 16'h8722);
    expect_next("R3 third", 16'h8133);
    expect_next("R3 drained", 16'h0000);
  endtask

  task automatic t_simul();
    @(negedge clk);
    line_stb = '0;
    line_stb[12] = 1'b1; line_data[12*8 +: 8] = 8'hC0;
    line_stb[3]  = 1'b1; line_data[3*8 +: 8]  = 8'h30;
    line_stb[8]  = 1'b1; line_data[8*8 +: 8]  = 8'h80;
    @(negedge clk);
    line_stb = '0;
    wait_cyc(5);
    expect_next("R4 line3 first", 16'h8330);
    expect_next("R4 line8 second", 16'h8880);
    expect_next("R4 line12 third", 16'h8CC0);
  endtask

  task automatic t_empty();
    expect_next("R5 empty read a", 16'h0000);
    expect_next("R5 empty read b", 16'h0000);
    send(6, 8'h66, 0, 0, 0);
    wait_cyc(3);
    expect_next("R5 state intact", 16'h8666);
    expect_next("R5 still one entry", 16'h0000);
  endtask

  task automatic t_full();
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      line_stb[0] = 1'b1; line_data[7:0] = 8'(i);
    end
    @(negedge clk);
    line_stb = '0;
    wait_cyc(3);
    for (int i = 0; i < 64; i++) begin
      logic [15:0] v;
      reg_read(2'd1, v);
      check("R6 kept entry", v, {8'h80, 8'(i)});
    end
    expect_next("R6 dropped not stored", 16'h0000);
    send(4, 8'h77, 0, 0, 0);
    send(4, 8'h78, 0, 0, 0);
    wait_cyc(3);
    expect_next("R6 overrun marked", 16'hC477);
    expect_next("R6 mark cleared", 16'h8478);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    reg_write(2'd0, 16'h0040);
    reg_write(2'd2, 16'd0);
    check("R7 no irq when empty", {15'b0, irq}, 16'h0000);
    send(10, 8'h01, 0, 0, 0);
    wait_cyc(3);
    check("R7 irq alarm0", {15'b0, irq}, 16'h0001);
    reg_read(2'd1, v);
    wait_cyc(1);
    check("R7 irq drops after drain", {15'b0, irq}, 16'h0000);
    reg_write(2'd2, 16'd2);
    send(10, 8'h02, 0, 0, 0);
    send(10, 8'h03, 0, 0, 0);
    wait_cyc(3);
    check("R7 irq at level", {15'b0, irq}, 16'h0000);
    send(10, 8'h04, 0, 0, 0);
    wait_cyc(3);
    check("R7 irq above level", {15'b0, irq}, 16'h0001);
    reg_write(2'd0, 16'h0000);
    wait_cyc(2);
    check("R8 irq masked", {15'b0, irq}, 16'h0000);
    repeat (3) reg_read(2'd1, v);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    reg_write(2'd0, 16'hFFFF);
    reg_read(2'd0, v);
    check("R9 ctrl readback", v, 16'h0040);
    reg_write(2'd2, 16'd32);
    reg_read(2'd2, v);
    check("R9 alarm readback", v, 16'd32);
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, v);
    check("R9 ctrl cleared", v, 16'h0000);
  endtask

  task automatic t_holdover();
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      line_stb[i] = 1'b1; line_data[i*8 +: 8] = 8'(8'h10 + i);
    end
    @(negedge clk);
    line_stb = '0;
    line_stb[3] = 1'b1; line_data[31:24] = 8'h99;
    @(negedge clk);
    line_stb = '0;
    wait_cyc(6);
    expect_next("R10 line0", 16'h8010);
    expect_next("R10 line1", 16'h8111);
    expect_next("R10 line2", 16'h8212);
    expect_next("R10 held marked", 16'hC313);
    expect_next("R10 second dropped", 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_format();
    t_order();
    t_simul();
    t_empty();
    t_full();
    t_irq();
    t_regs();
    t_holdover();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule